// File: doc/BRIEF.md
# Eight-Channel Output Mode Controller with Limp-Home Override

This block decides, cycle by cycle, whether each of eight low-side output channels is driven and whether its off-state diagnostic current source is enabled. A 16-bit control word holds a 2-bit mode per channel. The word is loaded from a serial-interface write stream. The modes combine with four external drive pins, a per-channel latched-fault input and a chip-level reset pin. A limp-home input gives a fail-safe path. While it is high, the pins drive the first four channels directly and the serial link is locked out.

The control word arrives on a valid/ready stream. A write is taken on a cycle where `wr_valid` and `wr_ready` are both high. `wr_ready` drops while the reset pin is low or limp-home is active. The producer must hold `wr_valid` and `wr_data` until the handshake completes, or drop the word. No write is buffered. The drive pins and limp-home pass through two-flop synchronizers. The fault latch stays outside the block; `standby` tells it when a channel's flags should be cleared.

Top module: `chan_mode_ctrl`

## Requirements
- R1: Channel k (0 to 7) takes its mode from control bits [2k+1:2k]. Mode codes: 00 standby, 01 pin-follow, 10 forced on, 11 forced off.
- R2: In standby (00), the channel's gate and diagnostic enables are 0 and its `standby` bit is 1.
- R3: In pin-follow (01), channel k's gate equals synchronized pin (k mod 4). A pin change reaches `gate_en` after two rising clock edges. The diagnostic enable is 1 whenever the gate is 0.
- R4: Forced on (10) sets the gate to 1 and the diagnostic enable to 0. Forced off (11) sets the gate to 0 and the diagnostic enable to 1.
- R5: Outside limp-home, a channel whose `fault_latched` bit is 1 has its gate at 0 in every mode.
- R6: System reset (`rst_n` low) or a low on `rst_pin_n` sets every control bit to 1. While `rst_pin_n` is low, all gate and diagnostic enables are 0 and `wr_ready` is 0.
- R7: A write is accepted only when `wr_valid` and `wr_ready` are both 1, and it takes effect on the next cycle. A write offered while `wr_ready` is 0 leaves the control word unchanged.
- R8: While the synchronized limp-home input is high:
  - pin j drives channel j (j 0 to 3);
  - channels 4 to 7 are off;
  - all diagnostic enables are 0 and faults are ignored;
  - `wr_ready` is 0 and the control word is held at all ones.
- R9: Limp-home takes priority over a low `rst_pin_n`; the pin routing of R8 applies during reset.
- R10: `sleep` is 1 when limp-home is inactive and either `rst_pin_n` is low or all eight modes are standby.
- R11: On the cycle the synchronized limp-home input falls, `xfer_err_set` pulses high for exactly one cycle, to flag the next serial transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| rst_pin_n | input | 1 | Chip reset pin, active low, sampled on clk |
| drv_pins | input | 4 | External drive pins |
| limp_req | input | 1 | Limp-home request, active high |
| fault_latched | input | 8 | Per-channel latched protection fault |
| wr_valid | input | 1 | Control-word write valid |
| wr_ready | output | 1 | Control-word write ready |
| wr_data | input | 16 | Control word |
| gate_en | output | 8 | Per-channel gate enable |
| diag_en | output | 8 | Per-channel diagnostic current enable |
| standby | output | 8 | Per-channel standby indication |
| sleep | output | 1 | Low-power indication |
| xfer_err_set | output | 1 | One-cycle pulse when limp-home ends |

## Verification
The hardest state to reach is one where limp-home overlaps other conditions. These are a held-low reset pin, latched faults on routed channels, and a write offered during limp-home. The stimulus first loads an all-on control word and arms faults, then raises limp-home. A write is offered while `wr_ready` is low. On release, the outputs must show the all-ones word rather than the last word offered. The same sequence is repeated with the reset pin held low, to confirm that limp-home takes priority.

// File: rtl/chmc_pkg.sv
package chmc_pkg;
  typedef enum logic [1:0] {
    MODE_STBY = 2'b00,
    MODE_PIN  = 2'b01,
    MODE_ON   = 2'b10,
    MODE_OFF  = 2'b11
  } chan_mode_e;
endpackage

// File: rtl/chmc_sync.sv
module chmc_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/chmc_ctrl_reg.sv
module chmc_ctrl_reg #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_pin_n,
  input  logic             limp_s,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctrl_q,
  output logic             xfer_err_set
);
  logic limp_q;

  assign wr_ready = rst_pin_n && !limp_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '1;
      limp_q <= 1'b0;
    end else begin
      limp_q <= limp_s;
      if (!rst_pin_n || limp_s) ctrl_q <= '1;
      else if (wr_valid)        ctrl_q <= wr_data;
    end
  end

  assign xfer_err_set = limp_q && !limp_s;
endmodule

// File: rtl/chmc_chan_slice.sv
module chmc_chan_slice
  import chmc_pkg::*;
#(
  parameter bit LIMP_ROUTED = 1'b0
) (
  input  chan_mode_e mode,
  input  logic       pin_lvl,
  input  logic       limp_on,
  input  logic       rst_hold,
  input  logic       fault,
  output logic       gate,
  output logic       diag,
  output logic       stby
);
  logic mode_gate;

  always_comb begin
    unique case (mode)
      MODE_PIN: mode_gate = pin_lvl;
      MODE_ON:  mode_gate = 1'b1;
      default:  mode_gate = 1'b0;
    endcase
  end

  always_comb begin
    gate = 1'b0;
    diag = 1'b0;
    stby = 1'b0;
    if (limp_on) begin
      gate = LIMP_ROUTED ? pin_lvl : 1'b0;
    end else if (!rst_hold) begin
      gate = mode_gate && !fault;
      stby = (mode == MODE_STBY);
      diag = (mode == MODE_OFF) || ((mode == MODE_PIN) && !gate);
    end
  end
endmodule

// File: rtl/chan_mode_ctrl.sv
module chan_mode_ctrl
  import chmc_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int NUM_PIN     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rst_pin_n,
  input  logic [NUM_PIN-1:0]  drv_pins,
  input  logic                limp_req,
  input  logic [NUM_CH-1:0]   fault_latched,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [2*NUM_CH-1:0] wr_data,
  output logic [NUM_CH-1:0]   gate_en,
  output logic [NUM_CH-1:0]   diag_en,
  output logic [NUM_CH-1:0]   standby,
  output logic                sleep,
  output logic                xfer_err_set
);
  localparam int REG_W = 2 * NUM_CH;

  logic [NUM_PIN-1:0] pins_s;
  logic               limp_s;
  logic [REG_W-1:0]   ctrl_q;

  chmc_sync #(.W(NUM_PIN + 1), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({limp_req, drv_pins}),
    .q     ({limp_s, pins_s})
  );

  chmc_ctrl_reg #(.REG_W(REG_W)) u_reg (
    .clk          (clk),
    .rst_n        (rst_n),
    .rst_pin_n    (rst_pin_n),
    .limp_s       (limp_s),
    .wr_valid     (wr_valid),
    .wr_ready     (wr_ready),
    .wr_data      (wr_data),
    .ctrl_q       (ctrl_q),
    .xfer_err_set (xfer_err_set)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_chan
    chmc_chan_slice #(.LIMP_ROUTED(k < NUM_PIN)) u_slice (
      .mode     (chan_mode_e'(ctrl_q[2*k +: 2])),
      .pin_lvl  (pins_s[k % NUM_PIN]),
      .limp_on  (limp_s),
      .rst_hold (!rst_pin_n),
      .fault    (fault_latched[k]),
      .gate     (gate_en[k]),
      .diag     (diag_en[k]),
      .stby     (standby[k])
    );
  end

  assign sleep = !limp_s && (!rst_pin_n || (&standby));
endmodule

// File: rtl/chmc_checker.sv
module chmc_checker #(
  parameter int NUM_CH  = 8,
  parameter int NUM_PIN = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                rst_pin_n,
  input logic                limp_s,
  input logic [2*NUM_CH-1:0] ctrl_q,
  input logic [NUM_CH-1:0]   fault_latched,
  input logic [NUM_CH-1:0]   gate_en,
  input logic [NUM_CH-1:0]   diag_en,
  input logic [NUM_CH-1:0]   standby,
  input logic                sleep,
  input logic                xfer_err_set
);
  // R2
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((standby & (gate_en | diag_en)) == '0));

  // R4
  gate_diag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_en & diag_en) == '0));

  // R5
  fault_blocks_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !limp_s |-> ((gate_en & fault_latched) == '0));

  // R6
  rst_pin_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_pin_n |=> (ctrl_q == '1));

  // R8
  limp_upper_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limp_s |-> (gate_en[NUM_CH-1:NUM_PIN] == '0) && (diag_en == '0));

  // R8
  limp_holds_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    limp_s |=> (ctrl_q == '1));

  // R10
  sleep_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (gate_en == '0));

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err_set |-> $fell(limp_s));
endmodule

bind chan_mode_ctrl chmc_checker #(.NUM_CH(NUM_CH), .NUM_PIN(NUM_PIN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rst_pin_n     (rst_pin_n),
  .limp_s        (limp_s),
  .ctrl_q        (ctrl_q),
  .fault_latched (fault_latched),
  .gate_en       (gate_en),
  .diag_en       (diag_en),
  .standby       (standby),
  .sleep         (sleep),
  .xfer_err_set  (xfer_err_set)
);

// File: tb/tb_chan_mode_ctrl.sv
module tb_chan_mode_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rst_pin_n = 1'b1;
  logic [3:0]  drv_pins = '0;
  logic        limp_req = 1'b0;
  logic [7:0]  fault_latched = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [15:0] wr_data = '0;
  logic [7:0]  gate_en, diag_en, standby;
  logic        sleep, xfer_err_set;

  int checks = 0;
  int errors = 0;
  int err_pulses = 0;

  always #5 clk = ~clk;

  chan_mode_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rst_pin_n(rst_pin_n), .drv_pins(drv_pins),
    .limp_req(limp_req), .fault_latched(fault_latched), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_data(wr_data), .gate_en(gate_en), .diag_en(diag_en),
    .standby(standby), .sleep(sleep), .xfer_err_set(xfer_err_set)
  );

  always @(negedge clk) if (rst_n && xfer_err_set) err_pulses++;

  // {ctrl, pins, fault, exp_gate, exp_diag, exp_stby, exp_sleep}
  typedef struct packed {
    logic [15:0] ctrl;
    logic [3:0]  pins;
    logic [7:0]  fault;
    logic [7:0]  gate;
    logic [7:0]  diag;
    logic [7:0]  stby;
    logic        slp;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0000, 4'hF,    8'h00, 8'h00, 8'h00, 8'hFF, 1'b1},
    '{16'h5555, 4'b0101, 8'h00, 8'h55, 8'hAA, 8'h00, 1'b0},
    '{16'hAAAA, 4'h0,    8'h0F, 8'hF0, 8'h00, 8'h00, 1'b0},
    '{16'hFFFF, 4'hF,    8'h00, 8'h00, 8'hFF, 8'h00, 1'b0},
    '{16'hC9E4, 4'b0010, 8'h00, 8'h26, 8'h98, 8'h41, 1'b0},
    '{16'hC9E4, 4'hF,    8'h12, 8'h24, 8'h9A, 8'h41, 1'b0}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_word(input logic [15:0] w);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = w;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);
    // R6 reset state: all modes 11
    chk("R6 reset gate", gate_en, 8'h00);
    chk("R6 reset diag", diag_en, 8'hFF);
    chk("R6 reset stby", standby, 8'h00);
    chk("R7 ready idle", wr_ready, 1'b1);

    // R1 R2 R3 R4 R5 R10 vector table
    for (int v = 0; v < NVEC; v++) begin
      drv_pins = VECS[v].pins;
      fault_latched = VECS[v].fault;
      write_word(VECS[v].ctrl);
      wait_n(3);
      chk($sformatf("R1 R3 R4 R5 vec%0d gate", v), gate_en, VECS[v].gate);
      chk($sformatf("R2 R3 R4 vec%0d diag", v), diag_en, VECS[v].diag);
      chk($sformatf("R2 vec%0d stby", v), standby, VECS[v].stby);
      chk($sformatf("R10 vec%0d sleep", v), sleep, VECS[v].slp);
    end

    // R3 synchronizer latency
    fault_latched = '0;
    drv_pins = 4'h0;
    write_word(16'h5555);
    wait_n(3);
    drv_pins = 4'hF;
    wait_n(1);
    chk("R3 one edge", gate_en, 8'h00);
    wait_n(1);
    chk("R3 two edges", gate_en, 8'hFF);

    // R6 R7 R10 reset pin, refused write
    write_word(16'h0000);
    rst_pin_n = 1'b0;
    wait_n(2);
    chk("R6 rstpin gate", gate_en, 8'h00);
    chk("R6 rstpin diag", diag_en, 8'h00);
    chk("R6 rstpin ready", wr_ready, 1'b0);
    chk("R10 rstpin sleep", sleep, 1'b1);
    write_word(16'hAAAA);
    rst_pin_n = 1'b1;
    wait_n(2);
    chk("R7 refused write gate", gate_en, 8'h00);
    chk("R6 word all ones diag", diag_en, 8'hFF);

    // R8 R11 limp-home
    drv_pins = 4'b1010;
    write_word(16'hAAAA);
    wait_n(1);
    chk("R4 all on", gate_en, 8'hFF);
    limp_req = 1'b1;
    wait_n(4);
    fault_latched = 8'hFF;
    wait_n(1);
    chk("R8 limp gate", gate_en, 8'h0A);
    chk("R8 limp diag", diag_en, 8'h00);
    chk("R8 limp ready", wr_ready, 1'b0);
    chk("R10 limp sleep", sleep, 1'b0);
    write_word(16'h0000);
    fault_latched = 8'h00;
    err_pulses = 0;
    limp_req = 1'b0;
    wait_n(4);
    chk("R8 after limp gate", gate_en, 8'h00);
    chk("R8 after limp diag", diag_en, 8'hFF);
    chk("R11 err pulse count", err_pulses, 1);

    // R9 limp over reset pin
    rst_pin_n = 1'b0;
    drv_pins = 4'b0101;
    limp_req = 1'b1;
    wait_n(4);
    chk("R9 limp in reset gate", gate_en, 8'h05);
    chk("R9 limp in reset ready", wr_ready, 1'b0);
    limp_req = 1'b0;
    wait_n(4);
    chk("R9 back to reset gate", gate_en, 8'h00);
    chk("R10 back to reset sleep", sleep, 1'b1);
    rst_pin_n = 1'b1;
    wait_n(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule